// File: doc/BRIEF.md
# DMA Channel Register File with Byte Pointer

This block is the processor-facing register side of a four-channel DMA engine. The processor reaches it over an 8-bit I/O bus, one byte per access. Each channel keeps a 16-bit base address, a base count, a current address and a current count. Every 16-bit value is reached through a single byte-wide port. A shared byte-pointer state machine decides whether an access hits the low byte or the high byte. The block also decodes the control ports: command, request, single mask, mode, clear pointer, master clear, clear all masks and write all masks. It keeps a status byte, and it keeps a separate 8-bit page latch for each channel.

The transfer engine sits next to this block. It reports each completed transfer on `step_en` and `step_ch`, and it names the owning channel on `act_valid` and `act_ch`. In return the block steps that channel's current address and count, flags terminal count and drives the full 24-bit bus address. The address is the channel's page latch on top of its 16-bit current address. The 16-bit part wraps inside its 64K page, and the page latch never carries.

The byte pointer is a two-state machine. In `PTR_LO` the next access hits the low byte. In `PTR_HI` it hits the high byte. The transition `ADVANCE` flips the state on every read or write of a channel port. The transition `RESET_PTR`, taken on a clear-pointer write or a master-clear write, returns it to `PTR_LO` from either state.

Top module: `dma_regfile`

## Requirements
- R1: After reset, all four masks are set, the command and request registers are zero, every address, count, mode and page register is zero, the byte pointer is in PTR_LO and the latched terminal-count bits are clear.
- R2: Channel ports are the accesses with io_addr[4]=0. The channel is io_addr[3:2], and io_addr[1] selects address (0) or count (1). Each read or write of a channel port uses the low byte in PTR_LO and the high byte in PTR_HI, then toggles the pointer.
- R3: A write to offset 0x18 puts the pointer in PTR_LO, so the next channel access uses the low byte.
- R4: A byte write to a channel address or count port loads that byte into both the base and the current register.
- R5: A read of a channel port returns the selected byte of the current address or the current remaining count.
- R6: A step of a channel with a nonzero count lowers the count by one. It raises the address by one, or lowers it when mode bit 5 is set. Address 0xFFFF steps to 0x0000 and the page latch is unchanged.
- R7: A step of a channel whose count is zero pulses term_cnt in that cycle and latches that channel's status bit. Without auto-reload (mode bit 4 clear) the count becomes 0xFFFF and the address steps. With auto-reload, the current address and count are reloaded from the base registers.
- R8: A read of offset 0x10 returns status: bits 7:4 are the live drq inputs and bits 3:0 are the latched terminal-count bits. That read clears bits 3:0 unless a new terminal count occurs in the same cycle.
- R9: A write to 0x14 sets (bit 2 = 1) or clears (bit 2 = 0) the mask of the channel named by bits 1:0. A write to 0x1C clears all masks. A write to 0x1E loads all masks from bits 3:0.
- R10: A write to 0x16 stores data bits 7:2 as the mode of the channel named by bits 1:0. Channel i appears at mode_flat[6i+5:6i].
- R11: A write to 0x1A sets all masks and puts the pointer in PTR_LO. It also clears the latched status bits and the command and request registers. Address, count, mode and page values are kept.
- R12: When io_cs_page is high, io_addr[3:0] values 7, 3, 1 and 2 select the page latches of channels 0, 1, 2 and 3 for read and write. Other values read zero and ignore writes. While act_valid is high, dma_addr is {page[act_ch], current address[act_ch]}. Otherwise dma_addr is zero.
- R13: A write to 0x10 loads cmd_reg. A write to 0x12 sets or clears sw_req for the channel in bits 1:0, according to bit 2. Reads of the write-only control ports return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_cs_ctl | input | 1 | Selects the channel and control ports |
| io_cs_page | input | 1 | Selects the page latches |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_addr | input | 5 | Port offset; bit 0 ignored for control ports |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the strobe cycle |
| drq | input | 4 | Live request lines shown in status |
| step_en | input | 1 | Engine finished one transfer |
| step_ch | input | 2 | Channel that transferred |
| act_valid | input | 1 | A channel owns the bus |
| act_ch | input | 2 | Channel that owns the bus |
| dma_addr | output | 24 | Page plus current address of the active channel |
| term_cnt | output | 1 | Terminal count in the step cycle |
| ch_mask | output | 4 | Per-channel mask bits |
| sw_req | output | 4 | Software request bits |
| cmd_reg | output | 8 | Command register |
| mode_flat | output | 24 | Per-channel mode fields, 6 bits each |

## Verification
The assertions assume the bus never asserts io_wr and io_rd in the same cycle. They also assume that at most one of io_cs_ctl and io_cs_page is high during a strobe, and that a register write and an engine step never hit the same channel in the same cycle. Every bench task drives one strobe at a time and holds it for exactly one clock. Each task drops step_en before it programs a channel and steps only channels that no bus access touches in that cycle. A full 16-bit load is always preceded by a clear-pointer write.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
    localparam int NCH   = 4;
    localparam int CHW   = $clog2(NCH);
    localparam int DW    = 8;
    localparam int RW    = 16;
    localparam int PW    = 8;
    localparam int MODEW = 6;

    // word index io_addr[4:1] of control ports
    localparam logic [3:0] W_CMD     = 4'h8;
    localparam logic [3:0] W_REQ     = 4'h9;
    localparam logic [3:0] W_SMASK   = 4'hA;
    localparam logic [3:0] W_MODE    = 4'hB;
    localparam logic [3:0] W_CLRPTR  = 4'hC;
    localparam logic [3:0] W_MCLR    = 4'hD;
    localparam logic [3:0] W_CLRMASK = 4'hE;
    localparam logic [3:0] W_WRMASK  = 4'hF;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr
    import dma_rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic clear,
    output logic hi_sel
);
    ptr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_LO: begin
                if (clear)       state_d = PTR_LO;   // RESET_PTR
                else if (access) state_d = PTR_HI;   // ADVANCE
            end
            PTR_HI: begin
                if (clear || access) state_d = PTR_LO; // RESET_PTR / ADVANCE
            end
            default: state_d = PTR_LO;
        endcase
    end

    always_comb begin
        hi_sel = (state_q == PTR_HI);
    end

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hi_sel);
    assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !clear) |=> (hi_sel != $past(hi_sel)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          hi_sel,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    input  logic          dec,
    input  logic          autoinit,
    output logic [RW-1:0] cur_addr,
    output logic [RW-1:0] cur_cnt,
    output logic          tc
);
    logic [RW-1:0] base_addr, base_cnt;
    logic          do_step;

    assign tc      = step && (cur_cnt == '0);
    assign do_step = step && !wr_addr && !wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else if (wr_addr) begin
            if (hi_sel) begin
                base_addr[RW-1:DW] <= wdata;
                cur_addr[RW-1:DW]  <= wdata;
            end else begin
                base_addr[DW-1:0] <= wdata;
                cur_addr[DW-1:0]  <= wdata;
            end
        end else if (wr_cnt) begin
            if (hi_sel) begin
                base_cnt[RW-1:DW] <= wdata;
                cur_cnt[RW-1:DW]  <= wdata;
            end else begin
                base_cnt[DW-1:0] <= wdata;
                cur_cnt[DW-1:0]  <= wdata;
            end
        end else if (do_step) begin
            if (tc && autoinit) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_cnt  <= cur_cnt - 1'b1;
                cur_addr <= dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
            end
        end
    end

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && cur_cnt != '0) |=> (cur_cnt == $past(cur_cnt) - 1'b1));
    assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && !dec && cur_addr == '1 && !(tc && autoinit)) |=> (cur_addr == '0));
    assert_tc_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && tc && !autoinit) |=> (cur_cnt == '1));
    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && tc && autoinit) |=> (cur_cnt == $past(base_cnt)));
endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank
    import dma_rf_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [3:0]     nib,
    input  logic [DW-1:0]  wdata,
    input  logic           act_valid,
    input  logic [CHW-1:0] act_ch,
    input  logic [RW-1:0]  act_addr,
    output logic [DW-1:0]  rdata,
    output logic [PW+RW-1:0] full_addr
);
    logic [PW-1:0] page_q [NCH];
    logic          hit;
    logic [CHW-1:0] sel;

    always_comb begin
        hit = 1'b1;
        sel = '0;
        unique case (nib)
            4'h7:    sel = 2'd0;
            4'h3:    sel = 2'd1;
            4'h1:    sel = 2'd2;
            4'h2:    sel = 2'd3;
            default: hit = 1'b0;
        endcase
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_page
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          page_q[i] <= '0;
                else if (wr_en && hit && sel == CHW'(i)) page_q[i] <= wdata;
            end
        end
    endgenerate

    assign rdata     = hit ? page_q[sel] : '0;
    assign full_addr = act_valid ? {page_q[act_ch], act_addr} : '0;
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_rf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_cs_ctl,
    input  logic                 io_cs_page,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [4:0]           io_addr,
    input  logic [DW-1:0]        io_wdata,
    output logic [DW-1:0]        io_rdata,
    input  logic [NCH-1:0]       drq,
    input  logic                 step_en,
    input  logic [CHW-1:0]       step_ch,
    input  logic                 act_valid,
    input  logic [CHW-1:0]       act_ch,
    output logic [PW+RW-1:0]     dma_addr,
    output logic                 term_cnt,
    output logic [NCH-1:0]       ch_mask,
    output logic [NCH-1:0]       sw_req,
    output logic [DW-1:0]        cmd_reg,
    output logic [NCH*MODEW-1:0] mode_flat
);
    logic [3:0]       widx;
    logic             ch_port, ctl_wr, ctl_rd, page_wr;
    logic             ptr_acc, ptr_clr, hi_sel, mclr, stat_rd;
    logic [RW-1:0]    cur_addr_a [NCH];
    logic [RW-1:0]    cur_cnt_a  [NCH];
    logic [MODEW-1:0] mode_q     [NCH];
    logic [NCH-1:0]   tc_vec, tc_lat;
    logic [DW-1:0]    page_rdata;
    logic [RW-1:0]    sel_word;
    logic [CHW-1:0]   wsel;

    assign widx    = io_addr[4:1];
    assign ch_port = !io_addr[4];
    assign ctl_wr  = io_cs_ctl && io_wr;
    assign ctl_rd  = io_cs_ctl && io_rd;
    assign page_wr = io_cs_page && io_wr;
    assign ptr_acc = io_cs_ctl && (io_wr || io_rd) && ch_port;
    assign mclr    = ctl_wr && widx == W_MCLR;
    assign ptr_clr = (ctl_wr && widx == W_CLRPTR) || mclr;
    assign stat_rd = ctl_rd && widx == W_CMD;
    assign wsel    = io_wdata[CHW-1:0];

    dma_byte_ptr u_ptr (
        .clk(clk), .rst_n(rst_n), .access(ptr_acc), .clear(ptr_clr), .hi_sel(hi_sel)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic hit_ch;
            assign hit_ch = ctl_wr && ch_port && io_addr[3:2] == CHW'(i);
            dma_chan_regs u_ch (
                .clk(clk), .rst_n(rst_n),
                .wr_addr(hit_ch && !io_addr[1]),
                .wr_cnt(hit_ch && io_addr[1]),
                .hi_sel(hi_sel), .wdata(io_wdata),
                .step(step_en && step_ch == CHW'(i)),
                .dec(mode_q[i][3]), .autoinit(mode_q[i][2]),
                .cur_addr(cur_addr_a[i]), .cur_cnt(cur_cnt_a[i]), .tc(tc_vec[i])
            );
            assign mode_flat[i*MODEW +: MODEW] = mode_q[i];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              mode_q[i] <= '0;
                else if (ctl_wr && widx == W_MODE && wsel == CHW'(i))
                    mode_q[i] <= io_wdata[DW-1:2];
            end
        end
    endgenerate

    assign term_cnt = |tc_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_mask <= '1;
            sw_req  <= '0;
            cmd_reg <= '0;
            tc_lat  <= '0;
        end else if (mclr) begin
            ch_mask <= '1;
            sw_req  <= '0;
            cmd_reg <= '0;
            tc_lat  <= '0;
        end else begin
            tc_lat <= (stat_rd ? '0 : tc_lat) | tc_vec;
            if (ctl_wr) begin
                unique case (widx)
                    W_CMD:     cmd_reg       <= io_wdata;
                    W_REQ:     sw_req[wsel]  <= io_wdata[2];
                    W_SMASK:   ch_mask[wsel] <= io_wdata[2];
                    W_CLRMASK: ch_mask       <= '0;
                    W_WRMASK:  ch_mask       <= io_wdata[NCH-1:0];
                    default:   ;
                endcase
            end
        end
    end

    dma_page_bank u_page (
        .clk(clk), .rst_n(rst_n), .wr_en(page_wr), .nib(io_addr[3:0]),
        .wdata(io_wdata), .act_valid(act_valid), .act_ch(act_ch),
        .act_addr(cur_addr_a[act_ch]), .rdata(page_rdata), .full_addr(dma_addr)
    );

    assign sel_word = io_addr[1] ? cur_cnt_a[io_addr[3:2]] : cur_addr_a[io_addr[3:2]];

    always_comb begin
        io_rdata = '0;
        if (io_cs_page)
            io_rdata = page_rdata;
        else if (io_cs_ctl) begin
            if (ch_port)
                io_rdata = hi_sel ? sel_word[RW-1:DW] : sel_word[DW-1:0];
            else if (widx == W_CMD)
                io_rdata = {drq, tc_lat};
        end
    end

    assert_rw_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_rd));
    assert_mclr_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (ch_mask == '1 && cmd_reg == '0 && sw_req == '0));
    assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !step_en && !mclr) |=> (tc_lat == '0));
    assert_tc_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (term_cnt && !mclr) |=> (tc_lat != '0));
    assert_addr_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (dma_addr[RW-1:0] == cur_addr_a[act_ch]));
endmodule

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;
    logic clk = 0, rst_n = 0;
    logic io_cs_ctl = 0, io_cs_page = 0, io_wr = 0, io_rd = 0;
    logic [4:0] io_addr = 0;
    logic [7:0] io_wdata = 0, io_rdata;
    logic [3:0] drq = 0;
    logic step_en = 0, act_valid = 0;
    logic [1:0] step_ch = 0, act_ch = 0;
    logic [23:0] dma_addr, mode_flat;
    logic term_cnt;
    logic [3:0] ch_mask, sw_req;
    logic [7:0] cmd_reg;
    int vectors = 0, fails = 0;
    logic [7:0] rb;

    always #4 clk = ~clk;

    dma_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .io_cs_ctl(io_cs_ctl), .io_cs_page(io_cs_page),
        .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .drq(drq), .step_en(step_en), .step_ch(step_ch),
        .act_valid(act_valid), .act_ch(act_ch), .dma_addr(dma_addr),
        .term_cnt(term_cnt), .ch_mask(ch_mask), .sw_req(sw_req),
        .cmd_reg(cmd_reg), .mode_flat(mode_flat)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr_ctl(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        io_cs_ctl = 1; io_wr = 1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_cs_ctl = 0; io_wr = 0;
    endtask

    task automatic rd_ctl(logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        io_cs_ctl = 1; io_rd = 1; io_addr = a;
        #2 d = io_rdata;
        @(negedge clk);
        io_cs_ctl = 0; io_rd = 0;
    endtask

    task automatic wr_page(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        io_cs_page = 1; io_wr = 1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_cs_page = 0; io_wr = 0;
    endtask

    task automatic rd_page(logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        io_cs_page = 1; io_rd = 1; io_addr = a;
        #2 d = io_rdata;
        @(negedge clk);
        io_cs_page = 0; io_rd = 0;
    endtask

    task automatic load16(logic [4:0] a, logic [15:0] v);
        wr_ctl(5'h18, 8'h00);
        wr_ctl(a, v[7:0]);
        wr_ctl(a, v[15:8]);
    endtask

    task automatic read16(logic [4:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        wr_ctl(5'h18, 8'h00);
        rd_ctl(a, lo);
        rd_ctl(a, hi);
        v = {hi, lo};
    endtask

    task automatic do_step(logic [1:0] ch, output logic tc);
        @(negedge clk);
        step_en = 1; step_ch = ch;
        #2 tc = term_cnt;
        @(negedge clk);
        step_en = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 masks", ch_mask, 4'hF);
        chk("R1 cmd", cmd_reg, 0);
        chk("R1 req", sw_req, 0);
        chk("R1 mode", mode_flat, 0);
        chk("R1 dma_addr", dma_addr, 0);
        rd_ctl(5'h10, rb);
        chk("R1 status", rb, 0);
    endtask

    task automatic t_pointer;
        logic [15:0] v;
        load16(5'h00, 16'hBEEF);
        read16(5'h00, v);
        chk("R2 R4 R5 addr ch0", v, 16'hBEEF);
        rd_ctl(5'h00, rb);              // pointer now high
        chk("R2 low byte first", rb, 8'hEF);
        wr_ctl(5'h18, 0);
        rd_ctl(5'h00, rb);
        chk("R3 clear ptr", rb, 8'hEF);
        rd_ctl(5'h00, rb);
        chk("R2 read toggles", rb, 8'hBE);
        load16(5'h0A, 16'h1234);
        read16(5'h0A, v);
        chk("R4 R5 count ch2", v, 16'h1234);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        logic tc;
        load16(5'h04, 16'hFFFF);
        load16(5'h06, 16'h0005);
        wr_page(5'h03, 8'h12);
        @(negedge clk);
        act_valid = 1; act_ch = 1;
        #1 chk("R12 full addr", dma_addr, 24'h12FFFF);
        do_step(2'd1, tc);
        chk("R6 no tc", tc, 0);
        #1 chk("R6 wrap in page", dma_addr, 24'h120000);
        act_valid = 0;
        read16(5'h06, v);
        chk("R6 count dec", v, 16'h0004);
        load16(5'h00, 16'h0000);
        load16(5'h02, 16'h0003);
        wr_ctl(5'h16, 8'h20);           // ch0 decrement
        do_step(2'd0, tc);
        read16(5'h00, v);
        chk("R6 decrement", v, 16'hFFFF);
        chk("R10 mode ch0", mode_flat[5:0], 6'h08);
    endtask

    task automatic t_tc;
        logic [15:0] v;
        logic tc;
        load16(5'h08, 16'h1000);
        load16(5'h0A, 16'h0001);
        wr_ctl(5'h16, 8'h02);
        do_step(2'd2, tc);
        chk("R7 no tc at 1", tc, 0);
        do_step(2'd2, tc);
        chk("R7 tc pulse", tc, 1);
        read16(5'h0A, v);
        chk("R7 count FFFF", v, 16'hFFFF);
        read16(5'h08, v);
        chk("R7 addr stepped", v, 16'h1002);
        drq = 4'b1010;
        rd_ctl(5'h10, rb);
        chk("R8 status", rb, 8'hA4);
        rd_ctl(5'h10, rb);
        chk("R8 clear on read", rb, 8'hA0);
        drq = 0;
        load16(5'h0C, 16'h2000);
        load16(5'h0E, 16'h0000);
        wr_ctl(5'h16, 8'h13);           // ch3 auto-reload
        chk("R10 mode ch3", mode_flat[23:18], 6'h04);
        do_step(2'd3, tc);
        chk("R7 tc reload", tc, 1);
        read16(5'h0C, v);
        chk("R7 reload addr", v, 16'h2000);
        read16(5'h0E, v);
        chk("R7 reload count", v, 16'h0000);
    endtask

    task automatic t_masks;
        wr_ctl(5'h1C, 0);
        @(negedge clk) chk("R9 clear all", ch_mask, 0);
        wr_ctl(5'h14, 8'h06);
        @(negedge clk) chk("R9 single set", ch_mask, 4'b0100);
        wr_ctl(5'h1E, 8'h0B);
        @(negedge clk) chk("R9 write all", ch_mask, 4'b1011);
        wr_ctl(5'h14, 8'h01);
        @(negedge clk) chk("R9 single clear", ch_mask, 4'b1001);
    endtask

    task automatic t_cmd_mclr;
        logic [15:0] v;
        logic tc;
        wr_ctl(5'h10, 8'h5A);
        wr_ctl(5'h12, 8'h04);
        @(negedge clk);
        chk("R13 cmd", cmd_reg, 8'h5A);
        chk("R13 req", sw_req, 4'b0001);
        rd_ctl(5'h16, rb);
        chk("R13 write-only reads zero", rb, 0);
        load16(5'h04, 16'h00FF);
        load16(5'h06, 16'h0000);
        do_step(2'd1, tc);              // latch status bit 1
        wr_ctl(5'h18, 0);
        wr_ctl(5'h04, 8'h77);           // pointer high
        wr_ctl(5'h1A, 0);
        @(negedge clk);
        chk("R11 masks", ch_mask, 4'hF);
        chk("R11 cmd", cmd_reg, 0);
        chk("R11 req", sw_req, 0);
        rd_ctl(5'h10, rb);
        chk("R11 status", rb, 0);
        rd_ctl(5'h04, rb);
        chk("R11 ptr low", rb, 8'h77);
        chk("R11 mode kept", mode_flat[23:18], 6'h04);
    endtask

    task automatic t_page;
        wr_page(5'h07, 8'hA0);
        wr_page(5'h01, 8'hA2);
        wr_page(5'h02, 8'hA3);
        wr_page(5'h05, 8'hEE);          // unmapped
        rd_page(5'h07, rb); chk("R12 page ch0", rb, 8'hA0);
        rd_page(5'h03, rb); chk("R12 page ch1", rb, 8'h12);
        rd_page(5'h01, rb); chk("R12 page ch2", rb, 8'hA2);
        rd_page(5'h02, rb); chk("R12 page ch3", rb, 8'hA3);
        rd_page(5'h05, rb); chk("R12 unmapped", rb, 0);
        @(negedge clk);
        act_valid = 1; act_ch = 3;
        #1 chk("R12 ch3 addr", dma_addr, 24'hA32000);
        act_valid = 0;
        #1 chk("R12 idle zero", dma_addr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_pointer;
        t_wrap;
        t_tc;
        t_masks;
        t_cmd_mclr;
        t_page;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule